// File: doc/BRIEF.md
# PAL Composite Sync Timing Generator

This block produces the active-low composite sync for a 625-line interlaced monochrome PAL raster. It runs from a 16 MHz system clock, so each 64 µs line is 1024 clock cycles long. Every line is handled as two half-lines of 512 cycles. A sync pulse can start at the beginning of each half-line, which gives one possible pulse every 32 µs.

The low time of each half-line comes from a frame-long sequence of 1250 entries. The block computes each entry from its index; there is no stored table. The sequence holds broad pulses, equalizing pulses, normal line pulses and empty half-lines, all in the order the raster standard requires. Each width is picked up early in the half-line before the one it applies to. It waits in a shadow register and becomes active only at the next half-line boundary, so a pulse that is already running is never changed.

Next to the sync, the block gives later raster stages a half-line index, a line number, a field flag and a one-cycle marker for the point where active video starts on each visible line.

Top module: `pal_sync_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the half-line index, line number and field flag are set to 0 and the cycle position goes back to the start of a half-line. The width in effect is already the width of entry 0 (broad), so `syncN` is 0 in the first cycle after reset.
- R2: The half-line index advances by one every `HALF_CYCLES` (512) clocks, and wraps from `HALVES-1` (1249) to 0.
- R3: Within a half-line, `syncN` is 0 from cycle 0 for exactly the width in effect and is then 1 up to the end of the half-line. A width of 0 keeps `syncN` at 1 for the whole half-line.
- R4: Let k be the half-line index modulo 625. The width is `BROAD_W` (437) for k 0 to 4. It is `EQ_W` (38) for k 5 to 9 and for k 620 to 624. For every other k it is `NORMAL_W` (75) when the index itself is even and 0 when the index is odd.
- R5: A half-line's width is read at cycle `FETCH_AT` (128) of the half-line before it and takes effect only at the following boundary. As a result, `syncN` falls only in the first cycle of a half-line.
- R6: `lineNum` steps by one each time the half-line index moves from an odd value to the next even value, and returns to 0 with the index. Its value is always the index divided by two.
- R7: `fieldOdd` is 0 for half-line indices 0 to 624 and 1 for indices 625 to 1249.
- R8: `activeStart` is 1 for one cycle only, at cycle `ACT_AT` (219) of every half-line whose width is `NORMAL_W`. It stays 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz in the target) |
| rst | input | 1 | Synchronous reset, active high |
| syncN | output | 1 | Composite sync, low while a pulse is asserted |
| halfIdx | output | 11 | Index of the current half-line, 0 to 1249 |
| lineNum | output | 10 | Current line number, 0 to 624 |
| fieldOdd | output | 1 | 0 in the first field, 1 in the second |
| activeStart | output | 1 | One-cycle marker at the start of active video |

## Verification
The bench runs more than a whole frame with smaller cycle counts. This covers every kind of half-line: broad, both groups of equalizing pulses, normal line heads, empty odd halves, and the shifted half-line phase of the second field. Counting low cycles per half-line separates the width sequence from the pulse shape. Watching where each falling edge lands separates a correct boundary-timed load from a width that takes effect at the fetch point. Running past the last entry exercises the wraps of the index, the line number and the field. A second reset part-way through a run shows that the first half-line after reset already carries a valid broad pulse.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;

  typedef struct packed {
    logic halfEnd;
    logic fetch;
    logic actHit;
  } sync_strobe_t;

  typedef enum logic [1:0] {
    KIND_BROAD,
    KIND_EQUAL,
    KIND_NORMAL
  } half_kind_t;

endpackage

// File: rtl/pal_sync_ctrl.sv
module pal_sync_ctrl
  import pal_sync_pkg::*;
#(
  parameter int HALF_CYCLES = 512,
  parameter int FETCH_AT    = 128,
  parameter int ACT_AT      = 219,
  parameter int CW          = $clog2(HALF_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cyc,
  output sync_strobe_t  strb
);

  localparam logic [CW-1:0] LastCyc  = CW'(HALF_CYCLES - 1);
  localparam logic [CW-1:0] FetchCyc = CW'(FETCH_AT);
  localparam logic [CW-1:0] ActCyc   = CW'(ACT_AT);

  always_ff @(posedge clk) begin
    if (rst)               cyc <= '0;
    else if (strb.halfEnd) cyc <= '0;
    else                   cyc <= cyc + 1'b1;
  end

  always_comb begin
    strb.halfEnd = (cyc == LastCyc);
    strb.fetch   = (cyc == FetchCyc);
    strb.actHit  = (cyc == ActCyc);
  end

endmodule

// File: rtl/pal_sync_seq.sv
module pal_sync_seq
  import pal_sync_pkg::*;
#(
  parameter int HALVES   = 1250,
  parameter int VBLK     = 5,
  parameter int NORMAL_W = 75,
  parameter int EQ_W     = 38,
  parameter int BROAD_W  = 437,
  parameter int CW       = 9,
  parameter int HW       = $clog2(HALVES)
) (
  input  logic [HW-1:0] idx,
  output logic [CW-1:0] width
);

  localparam int FIELD = HALVES / 2;
  localparam logic [HW-1:0] FieldLen  = HW'(FIELD);
  localparam logic [HW-1:0] BroadEnd  = HW'(VBLK);
  localparam logic [HW-1:0] PostEnd   = HW'(2 * VBLK);
  localparam logic [HW-1:0] PreStart  = HW'(FIELD - VBLK);

  logic [HW-1:0] k;
  half_kind_t    kind;

  always_comb begin
    k = (idx >= FieldLen) ? idx - FieldLen : idx;
    if (k < BroadEnd)       kind = KIND_BROAD;
    else if (k < PostEnd)   kind = KIND_EQUAL;
    else if (k >= PreStart) kind = KIND_EQUAL;
    else                    kind = KIND_NORMAL;
    case (kind)
      KIND_BROAD: width = CW'(BROAD_W);
      KIND_EQUAL: width = CW'(EQ_W);
      default:    width = idx[0] ? '0 : CW'(NORMAL_W);
    endcase
  end

endmodule

// File: rtl/pal_sync_dp.sv
module pal_sync_dp
  import pal_sync_pkg::*;
#(
  parameter int HALVES   = 1250,
  parameter int NORMAL_W = 75,
  parameter int CW       = 9,
  parameter int HW       = $clog2(HALVES),
  parameter int LW       = $clog2(HALVES / 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cyc,
  input  sync_strobe_t  strb,
  input  logic [CW-1:0] nextWidth,
  output logic [HW-1:0] lookupIdx,
  output logic          syncN,
  output logic [HW-1:0] halfIdx,
  output logic [LW-1:0] lineNum,
  output logic          fieldOdd,
  output logic          activeStart
);

  localparam logic [HW-1:0] LastHalf  = HW'(HALVES - 1);
  localparam logic [HW-1:0] FieldLast = HW'(HALVES / 2 - 1);

  logic [CW-1:0] preloadW;
  logic [CW-1:0] activeW;
  logic          wrapHalf;

  assign wrapHalf  = (halfIdx == LastHalf);
  assign lookupIdx = rst ? '0 : (wrapHalf ? '0 : halfIdx + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      halfIdx  <= '0;
      lineNum  <= '0;
      fieldOdd <= 1'b0;
      preloadW <= nextWidth;
      activeW  <= nextWidth;
    end else begin
      if (strb.fetch) preloadW <= nextWidth;
      if (strb.halfEnd) begin
        activeW <= preloadW;
        halfIdx <= wrapHalf ? '0 : halfIdx + 1'b1;
        if (wrapHalf)        lineNum <= '0;
        else if (halfIdx[0]) lineNum <= lineNum + 1'b1;
        if (wrapHalf || halfIdx == FieldLast) fieldOdd <= ~fieldOdd;
      end
    end
  end

  assign syncN       = (cyc >= activeW);
  assign activeStart = strb.actHit && (activeW == CW'(NORMAL_W));

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
  import pal_sync_pkg::*;
#(
  parameter int HALF_CYCLES = 512,
  parameter int HALVES      = 1250,
  parameter int FETCH_AT    = 128,
  parameter int ACT_AT      = 219,
  parameter int NORMAL_W    = 75,
  parameter int EQ_W        = 38,
  parameter int BROAD_W     = 437,
  parameter int VBLK        = 5,
  localparam int CW         = $clog2(HALF_CYCLES),
  localparam int HW         = $clog2(HALVES),
  localparam int LW         = $clog2(HALVES / 2)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          syncN,
  output logic [HW-1:0] halfIdx,
  output logic [LW-1:0] lineNum,
  output logic          fieldOdd,
  output logic          activeStart
);

  logic [CW-1:0] cyc;
  sync_strobe_t  strb;
  logic [HW-1:0] lookupIdx;
  logic [CW-1:0] nextWidth;

  pal_sync_ctrl #(
    .HALF_CYCLES(HALF_CYCLES), .FETCH_AT(FETCH_AT), .ACT_AT(ACT_AT), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cyc(cyc), .strb(strb)
  );

  pal_sync_seq #(
    .HALVES(HALVES), .VBLK(VBLK), .NORMAL_W(NORMAL_W), .EQ_W(EQ_W),
    .BROAD_W(BROAD_W), .CW(CW), .HW(HW)
  ) u_seq (
    .idx(lookupIdx), .width(nextWidth)
  );

  pal_sync_dp #(
    .HALVES(HALVES), .NORMAL_W(NORMAL_W), .CW(CW), .HW(HW), .LW(LW)
  ) u_dp (
    .clk(clk), .rst(rst), .cyc(cyc), .strb(strb), .nextWidth(nextWidth),
    .lookupIdx(lookupIdx), .syncN(syncN), .halfIdx(halfIdx),
    .lineNum(lineNum), .fieldOdd(fieldOdd), .activeStart(activeStart)
  );

endmodule

// File: rtl/pal_sync_chk.sv
module pal_sync_chk #(
  parameter int HALVES = 1250,
  parameter int HW     = $clog2(HALVES),
  parameter int LW     = $clog2(HALVES / 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          syncN,
  input logic [HW-1:0] halfIdx,
  input logic [LW-1:0] lineNum,
  input logic          fieldOdd,
  input logic          activeStart
);

  localparam logic [HW-1:0] LastHalf = HW'(HALVES - 1);
  localparam logic [HW-1:0] FieldLen = HW'(HALVES / 2);

  p_index_range_r2: assert property (@(posedge clk) disable iff (rst)
    halfIdx <= LastHalf);

  p_index_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && halfIdx != $past(halfIdx)) |->
      halfIdx == (($past(halfIdx) == LastHalf) ? '0 : $past(halfIdx) + 1'b1));

  p_stays_high_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(syncN) && halfIdx == $past(halfIdx)) |-> syncN);

  p_fall_on_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(syncN)) |-> halfIdx != $past(halfIdx));

  p_line_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    lineNum == LW'(halfIdx >> 1));

  p_field_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    fieldOdd == (halfIdx >= FieldLen));

  p_marker_single_r8: assert property (@(posedge clk) disable iff (rst)
    activeStart |=> !activeStart);

  p_marker_after_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    activeStart |-> syncN);

endmodule

bind pal_sync_gen pal_sync_chk #(.HALVES(HALVES)) u_chk (
  .clk(clk), .rst(rst), .syncN(syncN), .halfIdx(halfIdx),
  .lineNum(lineNum), .fieldOdd(fieldOdd), .activeStart(activeStart)
);

// File: tb/sim_pal_sync_gen.sv
module sim_pal_sync_gen;

  localparam int HC  = 64;
  localparam int FA  = 16;
  localparam int AA  = 27;
  localparam int NW  = 9;
  localparam int EW  = 5;
  localparam int BW  = 55;
  localparam int VB  = 5;
  localparam int HV  = 1250;
  localparam int FLD = HV / 2;
  localparam int RUN = HV + 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic syncN, fieldOdd, activeStart;
  logic [10:0] halfIdx;
  logic [9:0]  lineNum;

  always #2 clk = ~clk;

  pal_sync_gen #(
    .HALF_CYCLES(HC), .HALVES(HV), .FETCH_AT(FA), .ACT_AT(AA),
    .NORMAL_W(NW), .EQ_W(EW), .BROAD_W(BW), .VBLK(VB)
  ) u0 (
    .clk(clk), .rst(rst), .syncN(syncN), .halfIdx(halfIdx),
    .lineNum(lineNum), .fieldOdd(fieldOdd), .activeStart(activeStart)
  );

  typedef struct {
    int idx;
    int width;
    int line;
    int field;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit released = 0;
  bit done = 0;

  function automatic int expWidth(int h);
    int k;
    k = (h >= FLD) ? h - FLD : h;
    if (k < VB) return BW;
    if (k < 2 * VB) return EW;
    if (k >= FLD - VB) return EW;
    return (h % 2 == 1) ? 0 : NW;
  endfunction

  task automatic check(string req, bit ok, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic pushAll();
    for (int n = 0; n < RUN; n++) begin
      int h;
      h = n % HV;
      q.push_back('{h, expWidth(h), h / 2, (h >= FLD) ? 1 : 0});
    end
  endtask

  // driver
  initial begin
    pushAll();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    released = 1'b1;
  end

  // monitor / scoreboard
  initial begin
    bit prevSync;
    wait (released);
    check("R1 sync low after reset", syncN == 1'b0, syncN, 0);
    check("R1 index after reset", halfIdx == 0, halfIdx, 0);
    check("R1 line after reset", lineNum == 0, lineNum, 0);
    check("R1 field after reset", fieldOdd == 1'b0, fieldOdd, 0);
    prevSync = 1'b1;
    while (q.size() > 0) begin
      exp_t it;
      bit iOk, sOk, lOk, fOk, aOk;
      int iA, sA, sE, sC, lA, fA, aA, aE, lowCnt, midFalls;
      it = q.pop_front();
      iOk = 1; sOk = 1; lOk = 1; fOk = 1; aOk = 1;
      iA = 0; sA = 0; sE = 0; sC = 0; lA = 0; fA = 0; aA = 0; aE = 0;
      lowCnt = 0; midFalls = 0;
      for (int c = 0; c < HC; c++) begin
        int eS, eA;
        eS = (c < it.width) ? 0 : 1;
        eA = (c == AA && it.width == NW) ? 1 : 0;
        if (iOk && int'(halfIdx) != it.idx) begin iOk = 0; iA = halfIdx; end
        if (sOk && int'(syncN) != eS) begin sOk = 0; sA = syncN; sE = eS; sC = c; end
        if (lOk && int'(lineNum) != it.line) begin lOk = 0; lA = lineNum; end
        if (fOk && int'(fieldOdd) != it.field) begin fOk = 0; fA = fieldOdd; end
        if (aOk && int'(activeStart) != eA) begin aOk = 0; aA = activeStart; aE = eA; end
        if (!syncN) lowCnt++;
        if (c != 0 && prevSync && !syncN) midFalls++;
        prevSync = syncN;
        @(negedge clk);
      end
      check($sformatf("R2 index in half %0d", it.idx), iOk, iA, it.idx);
      check($sformatf("R3 sync shape half %0d cycle %0d", it.idx, sC), sOk, sA, sE);
      check($sformatf("R4 low cycles half %0d", it.idx), lowCnt == it.width, lowCnt, it.width);
      check($sformatf("R5 mid-half falls half %0d", it.idx), midFalls == 0, midFalls, 0);
      check($sformatf("R6 line half %0d", it.idx), lOk, lA, it.line);
      check($sformatf("R7 field half %0d", it.idx), fOk, fA, it.field);
      check($sformatf("R8 active marker half %0d", it.idx), aOk, aA, aE);
    end
    // second reset in the middle of a half-line
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 index after mid-run reset", halfIdx == 0, halfIdx, 0);
    check("R1 sync low after mid-run reset", syncN == 1'b0, syncN, 0);
    check("R1 line after mid-run reset", lineNum == 0, lineNum, 0);
    repeat (BW + 5) @(negedge clk);
    check("R1 broad pulse ended after reset", syncN == 1'b1, syncN, 1);
    check("R1 still first half after reset", halfIdx == 0, halfIdx, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule